// File: doc/BRIEF.md
# DRAM Compressed Test-Mode Datapath

This block models the mode control and data steering of a x4 DRAM whose storage is built as 8-bit internal words. Every strobe and data pin is sampled on a system clock, and the block acts on strobe transitions seen between two samples. The row address is captured when the row strobe falls with the column strobe high. Each later column strobe fall in that row cycle is a read or a write, chosen by the write-enable level at that sample.

In normal mode, a column address selects one 4-bit half of an internal word. Column bit 0 picks the half, and the remaining row and column bits pick the word. In test mode the half-select bit is ignored. A write copies data pin 0 into all eight bits of the word. A read reports on every output pin whether the eight bits are all equal: ones mean pass, zeros mean fail. A tester can therefore check twice as many bits per access on a linear pattern.

Test mode starts with a cycle in which write-enable and the column strobe are both low when the row strobe falls. Three kinds of refresh cycle end it:
- a column-before-row refresh;
- a hidden refresh, in which the column strobe is held low across a row strobe restart;
- a row-only refresh, which is a row cycle that closes without any column strobe fall.

The array depth is set by parameters so that the model stays small.

Top module: `dram_tm_core`

## Requirements
- R1: After reset, test_mode_o, dq_oe_o and dq_o are all 0.
- R2: A row strobe fall sampled with cas_n_i=0 and we_n_i=0 sets test_mode_o on the next cycle. test_mode_o changes only on a row strobe edge.
- R3: A row strobe fall sampled with cas_n_i=0 and we_n_i=1 clears test_mode_o. This covers a hidden refresh, where the column strobe stays low across the row strobe restart.
- R4: A row cycle opened with cas_n_i=1 that closes (ras_n_i rises) without any column strobe fall clears test_mode_o.
- R5: In normal mode, a column strobe fall with we_n_i=0 writes dq_i into one half of the addressed word: bits 3:0 when column bit 0 is 0, bits 7:4 when it is 1. The other half is unchanged.
- R6: In normal mode, a column strobe fall with we_n_i=1 drives the selected half onto dq_o and sets dq_oe_o, both visible one cycle later.
- R7: In test mode, a write stores dq_i[0] into all eight bits of the word. dq_i[3:1] and column bit 0 are ignored.
- R8: In test mode, a read returns 4'b1111 when all eight bits of the word are equal and 4'b0000 otherwise. Column bit 0 is ignored.
- R9: Several column strobe falls within one row cycle each access the row captured at the row strobe fall.
- R10: A column strobe fall inside a refresh or test-entry row cycle neither writes the array nor drives the outputs.
- R11: dq_oe_o clears one cycle after the row strobe rises, and one cycle after a write column strobe fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| addr_i | input | ADDR_W | Multiplexed row/column address |
| dq_i | input | 4 | Write data |
| dq_o | output | 4 | Read data or compare result |
| dq_oe_o | output | 1 | Read data valid / output drive |
| test_mode_o | output | 1 | Compressed test mode active |

## Verification
Every result is registered on the clock edge that first samples the causing strobe transition, so mode changes, read data and dq_oe_o changes are all due exactly one cycle after the stimulus is applied. The bench drives inputs on the falling clock edge and samples directed results on the following falling edge, one half period after the registering edge. A behavioural reference model advances on each rising edge and is compared 1 ns later. Single-bit mismatches are made by writing differing halves in normal mode and then reading compressed.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned WORD_W = 2 * NIB_W;

  typedef enum logic [1:0] {
    RC_NONE,
    RC_ACCESS,
    RC_REFRESH,
    RC_TM_ENTRY
  } ras_cyc_e;
endpackage

// File: rtl/dtm_strobe_ctl.sv
module dtm_strobe_ctl
  import dtm_pkg::*;
#(
  parameter int unsigned ROW_W  = 4,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_n_i,
  input  logic              cas_n_i,
  input  logic              we_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ROW_W-1:0]  row_o,
  output logic              test_mode_o,
  output logic              acc_stb_o,
  output logic              ras_rise_o
);
  logic     ras_q, cas_q, cas_seen_q, tm_q;
  logic     ras_fall, cas_fall;
  ras_cyc_e cyc_q, cyc_d;
  logic [ROW_W-1:0] row_q;

  assign ras_fall   = ras_q & ~ras_n_i;
  assign ras_rise_o = ~ras_q & ras_n_i;
  assign cas_fall   = cas_q & ~cas_n_i;
  // column accesses only in cycles that opened with CAS high
  assign acc_stb_o  = ~ras_n_i & cas_fall & (cyc_q == RC_ACCESS);

  always_comb begin
    cyc_d = cyc_q;
    if (ras_fall) begin
      if (cas_n_i)     cyc_d = RC_ACCESS;
      else if (we_n_i) cyc_d = RC_REFRESH;
      else             cyc_d = RC_TM_ENTRY;
    end else if (ras_rise_o) begin
      cyc_d = RC_NONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_q      <= 1'b1;
      cas_q      <= 1'b1;
      cyc_q      <= RC_NONE;
      cas_seen_q <= 1'b0;
      tm_q       <= 1'b0;
      row_q      <= '0;
    end else begin
      ras_q <= ras_n_i;
      cas_q <= cas_n_i;
      cyc_q <= cyc_d;
      if (ras_fall)       cas_seen_q <= 1'b0;
      else if (acc_stb_o) cas_seen_q <= 1'b1;
      if (ras_fall && cas_n_i) row_q <= addr_i[ROW_W-1:0];
      if (ras_fall && !cas_n_i)
        tm_q <= ~we_n_i;
      else if (ras_rise_o && cyc_q == RC_ACCESS && !cas_seen_q)
        tm_q <= 1'b0;  // row-only refresh
    end
  end

  assign row_o       = row_q;
  assign test_mode_o = tm_q;
endmodule

// File: rtl/dtm_array.sv
module dtm_array
  import dtm_pkg::*;
#(
  parameter int unsigned IDX_W = 7
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] wmask_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [WORD_W-1:0] mem_q [DEPTH];

  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    always_ff @(posedge clk_i) begin
      if (we_i && wmask_i[b]) mem_q[idx_i][b] <= wdata_i[b];
    end
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/dtm_lane_map.sv
module dtm_lane_map
  import dtm_pkg::*;
(
  input  logic              test_mode_i,
  input  logic              half_i,
  input  logic [NIB_W-1:0]  dq_i,
  input  logic [WORD_W-1:0] rword_i,
  output logic [WORD_W-1:0] wmask_o,
  output logic [WORD_W-1:0] wdata_o,
  output logic [NIB_W-1:0]  rnib_o
);
  logic all_eq;

  assign all_eq = (rword_i == {WORD_W{rword_i[0]}});

  always_comb begin
    if (test_mode_i) begin
      wmask_o = '1;
      wdata_o = {WORD_W{dq_i[0]}};
    end else begin
      wmask_o = half_i ? {{NIB_W{1'b1}}, {NIB_W{1'b0}}} : {{NIB_W{1'b0}}, {NIB_W{1'b1}}};
      wdata_o = {dq_i, dq_i};
    end
  end

  for (genvar p = 0; p < NIB_W; p++) begin : g_pin
    assign rnib_o[p] = test_mode_i ? all_eq
                     : (half_i ? rword_i[NIB_W+p] : rword_i[p]);
  end
endmodule

// File: rtl/dram_tm_core.sv
module dram_tm_core
  import dtm_pkg::*;
#(
  parameter int unsigned ROW_W = 4,
  parameter int unsigned COL_W = 4,
  localparam int unsigned ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_n_i,
  input  logic              cas_n_i,
  input  logic              we_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        dq_i,
  output logic [3:0]        dq_o,
  output logic              dq_oe_o,
  output logic              test_mode_o
);
  localparam int unsigned IDX_W = ROW_W + COL_W - 1;

  logic [ROW_W-1:0]  row;
  logic              tm, acc_stb, ras_rise, wr_en, rd_en;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] wmask, wdata, rword;
  logic [NIB_W-1:0]  rnib, dq_q;
  logic              oe_q;

  dtm_strobe_ctl #(.ROW_W(ROW_W), .ADDR_W(ADDR_W)) u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .ras_n_i(ras_n_i), .cas_n_i(cas_n_i),
    .we_n_i(we_n_i), .addr_i(addr_i), .row_o(row), .test_mode_o(tm),
    .acc_stb_o(acc_stb), .ras_rise_o(ras_rise)
  );

  assign idx   = {row, addr_i[COL_W-1:1]};
  assign wr_en = acc_stb & ~we_n_i;
  assign rd_en = acc_stb & we_n_i;

  dtm_array #(.IDX_W(IDX_W)) u_arr (
    .clk_i(clk_i), .we_i(wr_en), .idx_i(idx), .wmask_i(wmask),
    .wdata_i(wdata), .rdata_o(rword)
  );

  dtm_lane_map u_map (
    .test_mode_i(tm), .half_i(addr_i[0]), .dq_i(dq_i), .rword_i(rword),
    .wmask_o(wmask), .wdata_o(wdata), .rnib_o(rnib)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dq_q <= '0;
      oe_q <= 1'b0;
    end else begin
      if (rd_en) dq_q <= rnib;
      if (ras_rise || wr_en) oe_q <= 1'b0;
      else if (rd_en)        oe_q <= 1'b1;
    end
  end

  assign dq_o        = dq_q;
  assign dq_oe_o     = oe_q;
  assign test_mode_o = tm;
endmodule

// File: rtl/dram_tm_core_chk.sv
module dram_tm_core_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ras_n_i,
  input logic       cas_n_i,
  input logic       we_n_i,
  input logic [3:0] dq_o,
  input logic       dq_oe_o,
  input logic       test_mode_o
);
  logic ras_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ras_d <= 1'b1;
    else         ras_d <= ras_n_i;
  end

  p_entry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_d && !ras_n_i && !cas_n_i && !we_n_i) |=> test_mode_o);

  p_mode_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_d == ras_n_i) |=> $stable(test_mode_o));

  p_cbr_exit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_d && !ras_n_i && !cas_n_i && we_n_i) |=> !test_mode_o);

  p_oe_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_d && ras_n_i) |=> !dq_oe_o);

  p_compress_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_oe_o && test_mode_o) |-> (dq_o == 4'h0 || dq_o == 4'hF));
endmodule

bind dram_tm_core dram_tm_core_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ras_n_i(ras_n_i), .cas_n_i(cas_n_i),
  .we_n_i(we_n_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o), .test_mode_o(test_mode_o)
);

// File: tb/tb_dram_tm_core.sv
`timescale 1ns/1ps
module tb_dram_tm_core;
  localparam int ROW_W = 4;
  localparam int COL_W = 4;
  localparam int AW = 4;
  localparam int WORDS = 1 << (ROW_W + COL_W - 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic ras_n = 1, cas_n = 1, we_n = 1;
  logic [AW-1:0] addr = '0;
  logic [3:0] dq = '0;
  logic [3:0] dq_o;
  logic dq_oe, tmode;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dram_tm_core #(.ROW_W(ROW_W), .COL_W(COL_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ras_n_i(ras_n), .cas_n_i(cas_n), .we_n_i(we_n),
    .addr_i(addr), .dq_i(dq), .dq_o(dq_o), .dq_oe_o(dq_oe), .test_mode_o(tmode)
  );

  // behavioural reference
  logic [7:0] m_mem [WORDS];
  int m_tm = 0, m_oe = 0, m_acc = 0, m_seen = 0, m_row = 0, p_ras = 1, p_cas = 1;
  logic [3:0] m_dq = 4'h0;

  initial for (int i = 0; i < WORDS; i++) m_mem[i] = 'x;

  always @(posedge clk) begin
    if (rst_n) begin
      int idx;
      logic [7:0] w;
      idx = m_row * (1 << (COL_W - 1)) + (int'(addr) >> 1);
      if (p_ras == 1 && ras_n == 0) begin
        if (cas_n == 0) begin m_acc = 0; m_tm = (we_n == 0); end
        else begin m_acc = 1; m_seen = 0; m_row = int'(addr); end
      end else if (p_ras == 0 && ras_n == 1) begin
        m_oe = 0;
        if (m_acc == 1 && m_seen == 0) m_tm = 0;
        m_acc = 0;
      end else if (ras_n == 0 && m_acc == 1 && p_cas == 1 && cas_n == 0) begin
        m_seen = 1;
        w = m_mem[idx];
        if (we_n == 0) begin
          m_oe = 0;
          if (m_tm == 1) m_mem[idx] = dq[0] ? 8'hFF : 8'h00;
          else if (addr[0]) m_mem[idx] = {dq, w[3:0]};
          else m_mem[idx] = {w[7:4], dq};
        end else begin
          m_oe = 1;
          if (m_tm == 1) m_dq = (w == 8'h00 || w == 8'hFF) ? 4'hF : 4'h0;
          else m_dq = addr[0] ? w[7:4] : w[3:0];
        end
      end
      p_ras = int'(ras_n);
      p_cas = int'(cas_n);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      check(tmode === (m_tm == 1), "R2 R3 R4 model mode", int'(tmode), m_tm);
      check(dq_oe === (m_oe == 1), "R6 R11 model oe", int'(dq_oe), m_oe);
      check(dq_o === m_dq, "R6 R8 model data", int'(dq_o), int'(m_dq));
    end
  end

  task automatic cyc(input logic r, c, w, input logic [AW-1:0] a, input logic [3:0] d);
    ras_n = r; cas_n = c; we_n = w; addr = a; dq = d;
    @(negedge clk);
  endtask
  task automatic open_row(input logic [AW-1:0] r);
    cyc(1, 1, 1, r, 0); cyc(0, 1, 1, r, 0);
  endtask
  task automatic close_row(); cyc(1, 1, 1, 0, 0); endtask
  task automatic wr(input logic [AW-1:0] c, input logic [3:0] d);
    cyc(0, 0, 0, c, d); cyc(0, 1, 1, c, d);
  endtask
  task automatic rd(input logic [AW-1:0] c, output logic [3:0] d, output logic oe);
    cyc(0, 0, 1, c, 0); d = dq_o; oe = dq_oe; cyc(0, 1, 1, c, 0);
  endtask
  task automatic enter_tm();
    cyc(1, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0); cyc(0, 0, 1, 0, 0); cyc(1, 1, 1, 0, 0);
  endtask
  task automatic cbr();
    cyc(1, 0, 1, 0, 0); cyc(0, 0, 1, 0, 0); cyc(1, 0, 1, 0, 0); cyc(1, 1, 1, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [3:0] d;
    logic oe;
    repeat (3) @(negedge clk);
    check(tmode === 0 && dq_oe === 0 && dq_o === 0, "R1 reset", {tmode, dq_oe, dq_o}, 0);
    rst_n = 1;
    @(negedge clk);

    // R5 R6 R9: two halves written and read back within one row cycle
    open_row(3);
    wr(4, 4'hA); wr(5, 4'h5);
    rd(4, d, oe);
    check(d === 4'hA, "R5 low half", d, 4'hA);
    check(oe === 1, "R6 oe after read", oe, 1);
    rd(5, d, oe);
    check(d === 4'h5, "R9 page second access", d, 4'h5);
    wr(6, 4'h3);
    check(dq_oe === 0, "R11 write clears oe", dq_oe, 0);
    rd(4, d, oe);
    close_row();
    check(dq_oe === 0, "R11 row close clears oe", dq_oe, 0);

    // R2 R7 R8: compressed write and read
    enter_tm();
    check(tmode === 1, "R2 entry", tmode, 1);
    open_row(2);
    wr(6, 4'b1110);
    rd(7, d, oe);
    check(d === 4'hF, "R8 equal bits pass", d, 4'hF);
    close_row();
    check(tmode === 1, "R2 stays after access cycle", tmode, 1);
    cbr();
    check(tmode === 0, "R3 cbr exit", tmode, 0);
    open_row(2);
    rd(6, d, oe);
    check(d === 4'h0, "R7 broadcast low half", d, 0);
    rd(7, d, oe);
    check(d === 4'h0, "R7 broadcast high half", d, 0);
    close_row();

    // R8: single-bit mismatch
    open_row(3);
    wr(4, 4'hF); wr(5, 4'hE);
    close_row();
    enter_tm();
    open_row(3);
    rd(4, d, oe);
    check(d === 4'h0, "R8 mismatch fails", d, 0);
    rd(5, d, oe);
    check(d === 4'h0, "R8 mismatch col0 ignored", d, 0);
    wr(5, 4'b0001);
    rd(4, d, oe);
    check(d === 4'hF, "R7 broadcast ones", d, 4'hF);
    close_row();

    // R4: row-only refresh
    cyc(0, 1, 1, 1, 0); cyc(0, 1, 1, 1, 0); close_row();
    check(tmode === 0, "R4 row-only exit", tmode, 0);

    // R3 hidden refresh and R10 ignored column fall
    open_row(1); wr(4, 4'h9); close_row();
    enter_tm();
    open_row(1);
    cyc(0, 0, 1, 4, 0);
    cyc(1, 0, 1, 4, 0);
    check(dq_oe === 0, "R11 oe cleared at restart", dq_oe, 0);
    cyc(0, 0, 1, 4, 0);
    check(tmode === 0, "R3 hidden refresh exit", tmode, 0);
    cyc(0, 1, 1, 4, 0);
    cyc(0, 0, 0, 4, 4'h6);
    check(dq_oe === 0, "R10 no drive in refresh", dq_oe, 0);
    cyc(1, 1, 1, 0, 0); cyc(1, 1, 1, 0, 0);
    open_row(1);
    rd(4, d, oe);
    check(d === 4'h9, "R10 no write in refresh", d, 4'h9);
    close_row();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule